// File: doc/BRIEF.md
# Serial EEPROM Bulk Erase/Write Controller

This block is the device-side logic of a three-wire serial EEPROM, reduced to its two whole-array commands: fill every word with ones, and fill every word with one shifted-in data value. While chip select is high, the host clocks a command frame in on the data input, one bit per rising edge of the serial clock, MSB first. When the host drops chip select after a complete and valid frame, the block starts an internal cycle. A counter on the system clock times this cycle, so the serial clock is not needed once the cycle has begun. The whole array is updated in the cycle's last clock.

A host that wants to know when the cycle is over keeps chip select low for at least the minimum deselect time and then raises it again. The data output then reports the cycle state: driven low while the cycle runs, driven high once it is over. While chip select is low the data output floats. A write-enable input gates both commands. The array has a combinational read port so that its contents can be inspected.

All pins are sampled on the system clock through two-flop synchronisers, and serial clock edges are found by edge detection on the synchronised signal.

Top module: `mw_bulk_ctrl`

## Requirements
- R1: After reset every word reads 0. A complete erase frame (bits 1, 00, then address-field top bits 10, the rest don't-care), followed by chip select falling, leaves every word all ones when the cycle ends.
- R2: A complete write frame (1, 00, address-field top bits 01, the rest don't-care, then DATA_W data bits MSB first), followed by chip select falling, stores that data word in every location, whatever the locations held before.
- R3: No array change and no cycle start happen while chip select stays high, even after a complete frame. The falling edge of chip select starts the cycle.
- R4: The cycle lasts exactly CYCLE_CLKS system clocks, with no serial clock edges needed. The array keeps its old contents until the cycle's last clock.
- R5: When chip select is raised during or after a cycle, the data output is driven 0 while the cycle runs and 1 once it has ended.
- R6: While chip select is low, the data output is high-impedance. After the host has read the ready status and dropped chip select, the next selection leaves the output high-impedance.
- R7: If chip select was low for fewer than CS_MIN_CLKS clocks before being raised, the data output stays high-impedance during that selection.
- R8: A frame completed while write-enable is low does not start a cycle and leaves the array unchanged.
- R9: A frame cut short by chip select falling leaves the array unchanged and starts no cycle.
- R10: Zeros clocked in before the start bit are skipped. A frame whose opcode is not 00, or whose qualifier is 00 or 11, is ignored.
- R11: A frame that completes while a cycle is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| wr_en | input | 1 | Write-enable level; low blocks both commands |
| do_pin | output | 1 | Serial data out: cycle status, or high-impedance |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Word at rd_addr |

## Verification
The checker watches four things on every clock. The output floats whenever the synchronised select is low. A cycle starts only on a deselected clock, with write-enable high and no cycle already running. Every start is followed by the busy state. Every busy period lasts exactly CYCLE_CLKS clocks. The directed scenarios cover what only whole transactions can show: the stored array values after each command, that nothing changes before the deselect edge or mid-cycle, the status polarity seen by a reselecting host, the minimum-deselect rule, and the rejection of truncated, malformed, disabled and overlapping frames.

// File: rtl/mw_pkg.sv
// Package: shared frame codes and receiver states for the bulk controller.
// Assumes the address field is at least two bits wide.
package mw_pkg;
    localparam logic [1:0] OPC_BULK   = 2'b00;
    localparam logic [1:0] QUAL_ERASE = 2'b10;
    localparam logic [1:0] QUAL_WRITE = 2'b01;

    typedef enum logic [2:0] {
        RX_IDLE,     // waiting for the start bit
        RX_HDR,      // collecting opcode and address field
        RX_DATA,     // collecting the data word
        RX_ERASE_OK, // complete erase frame held
        RX_WRITE_OK, // complete write frame held
        RX_SKIP      // frame rejected, ignore bits until deselect
    } rx_state_t;
endpackage

// File: rtl/mw_frame_rx.sv
// Frame receiver. It synchronises cs, sk and di to clk and shifts di on each
// synchronised sk rising edge while cs is high, MSB first. It decodes the two
// bulk commands. All progress is dropped whenever cs is low.
// Assumes sk stays stable for at least three clk periods in each phase.
module mw_frame_rx
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    output logic              cs_s,
    output logic              cs_fall,
    output logic              start_seen,
    output logic              erase_ok,
    output logic              write_ok,
    output logic [DATA_W-1:0] data_word
);
    localparam int HDR_W = 2 + ADDR_W;
    localparam int CNT_W = $clog2(HDR_W + DATA_W + 1);

    logic [1:0]        cs_sync, sk_sync, di_sync;
    logic              cs_prev, sk_prev;
    logic              sk_rise;
    rx_state_t         state;
    logic [HDR_W-1:0]  hdr_sr, hdr_nxt;
    logic [CNT_W-1:0]  bit_cnt;

    // Two-flop synchronisers and previous-value registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sync <= '0;
            sk_sync <= '0;
            di_sync <= '0;
            cs_prev <= 1'b0;
            sk_prev <= 1'b0;
        end else begin
            cs_sync <= {cs_sync[0], cs};
            sk_sync <= {sk_sync[0], sk};
            di_sync <= {di_sync[0], di};
            cs_prev <= cs_sync[1];
            sk_prev <= sk_sync[1];
        end
    end

    assign cs_s    = cs_sync[1];
    assign cs_fall = cs_prev && !cs_s;
    assign sk_rise = cs_s && sk_sync[1] && !sk_prev;
    assign hdr_nxt = {hdr_sr[HDR_W-2:0], di_sync[1]};

    // Frame state machine: start bit, header, optional data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            hdr_sr     <= '0;
            data_word  <= '0;
            bit_cnt    <= '0;
            start_seen <= 1'b0;
        end else begin
            start_seen <= 1'b0;
            if (!cs_s) begin
                state   <= RX_IDLE;
                bit_cnt <= '0;
            end else if (sk_rise) begin
                unique case (state)
                    RX_IDLE: begin
                        if (di_sync[1]) begin
                            state      <= RX_HDR;
                            bit_cnt    <= '0;
                            start_seen <= 1'b1;
                        end
                    end
                    RX_HDR: begin
                        hdr_sr  <= hdr_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(HDR_W - 1)) begin
                            bit_cnt <= '0;
                            if (hdr_nxt[HDR_W-1 -: 2] != OPC_BULK)
                                state <= RX_SKIP;
                            else if (hdr_nxt[ADDR_W-1 -: 2] == QUAL_ERASE)
                                state <= RX_ERASE_OK;
                            else if (hdr_nxt[ADDR_W-1 -: 2] == QUAL_WRITE)
                                state <= RX_DATA;
                            else
                                state <= RX_SKIP;
                        end
                    end
                    RX_DATA: begin
                        data_word <= {data_word[DATA_W-2:0], di_sync[1]};
                        bit_cnt   <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(DATA_W - 1))
                            state <= RX_WRITE_OK;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    assign erase_ok = (state == RX_ERASE_OK);
    assign write_ok = (state == RX_WRITE_OK);
endmodule

// File: rtl/mw_cycle_timer.sv
// Self-timed cycle. A start pulse latches the command kind and data and holds
// busy for exactly CYCLE_CLKS clocks. The fire pulse marks the last clock.
// Assumes CYCLE_CLKS >= 2 and that start is never raised while busy.
module mw_cycle_timer #(
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_erase,
    input  logic [DATA_W-1:0] start_data,
    output logic              busy,
    output logic              fire,
    output logic              fire_erase,
    output logic [DATA_W-1:0] fire_data
);
    localparam int CNT_W = $clog2(CYCLE_CLKS);

    logic [CNT_W-1:0] cnt;

    // Cycle counter and latched command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            fire_erase <= 1'b0;
            fire_data  <= '0;
        end else if (start) begin
            busy       <= 1'b1;
            cnt        <= '0;
            fire_erase <= start_erase;
            fire_data  <= start_data;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (fire)
                busy <= 1'b0;
        end
    end

    assign fire = busy && (cnt == CNT_W'(CYCLE_CLKS - 1));
endmodule

// File: rtl/mw_bulk_array.sv
// Storage array. On fire, every word is loaded at once with all ones (erase)
// or with the latched data word. Reset clears all words. The read port is
// combinational.
module mw_bulk_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              fire_erase,
    input  logic [DATA_W-1:0] fire_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // One replicated storage word per location.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[w] <= '0;
            else if (fire)
                mem[w] <= fire_erase ? {DATA_W{1'b1}} : fire_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_bulk_ctrl.sv
// Top level of the bulk erase/write controller. It ties together the frame
// receiver, the cycle timer and the array. It decides when a cycle may start
// and drives the ready/busy status on do_pin for a reselecting host.
// Assumes the host keeps sk low while changing cs.
module mw_bulk_ctrl #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int CYCLE_CLKS  = 1000,
    parameter int CS_MIN_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              wr_en,
    output logic              do_pin,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LOW_W = $clog2(CS_MIN_CLKS + 1);

    logic              cs_s, cs_fall, start_seen, erase_ok, write_ok;
    logic [DATA_W-1:0] data_word, fire_data;
    logic              start, busy, fire, fire_erase;
    logic              stat_armed, do_oe;
    logic [LOW_W-1:0]  low_cnt;

    mw_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .cs_fall(cs_fall), .start_seen(start_seen),
        .erase_ok(erase_ok), .write_ok(write_ok), .data_word(data_word)
    );

    // A cycle starts only on the deselect edge of a complete, enabled frame.
    assign start = cs_fall && (erase_ok || write_ok) && wr_en && !busy;

    mw_cycle_timer #(.DATA_W(DATA_W), .CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .start_erase(erase_ok),
        .start_data(data_word), .busy(busy), .fire(fire),
        .fire_erase(fire_erase), .fire_data(fire_data)
    );

    mw_bulk_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_erase(fire_erase),
        .fire_data(fire_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Deselect-time counter: restarts at each falling edge, saturates at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (cs_fall)
            low_cnt <= LOW_W'(1);
        else if (!cs_s && low_cnt != LOW_W'(CS_MIN_CLKS))
            low_cnt <= low_cnt + 1'b1;
    end

    // Status session: armed at cycle start, closed after a ready read or a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_armed <= 1'b0;
        else if (start)
            stat_armed <= 1'b1;
        else if (start_seen || (cs_fall && !busy))
            stat_armed <= 1'b0;
    end

    assign do_oe  = cs_s && stat_armed && (low_cnt == LOW_W'(CS_MIN_CLKS));
    assign do_pin = do_oe ? !busy : 1'bz;
endmodule

// File: rtl/mw_bulk_chk.sv
// Checker for mw_bulk_ctrl, bound into every instance. It watches output
// enable, start gating and cycle length.
module mw_bulk_chk #(
    parameter int CYCLE_CLKS = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic do_oe,
    input logic busy,
    input logic start,
    input logic wr_en
);
    logic [31:0] run_len;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_len <= '0;
        else if (busy)  run_len <= run_len + 1;
        else            run_len <= '0;
    end

    // R6
    float_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_oe);
    // R3
    start_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !cs_s);
    // R3
    start_enters_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R11
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    // R8
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> wr_en);
    // R4
    cycle_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(CYCLE_CLKS)));
endmodule

bind mw_bulk_ctrl mw_bulk_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .do_oe(do_oe),
    .busy(busy), .start(start), .wr_en(wr_en)
);

// File: tb/mw_bulk_ctrl_test.sv
// Directed bench for mw_bulk_ctrl: one task per scenario, each checking itself.
module mw_bulk_ctrl_test;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int CYC    = 200;
    localparam int CSMIN  = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, wr_en = 1'b1;
    logic do_pin;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    mw_bulk_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYC),
                   .CS_MIN_CLKS(CSMIN)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .wr_en(wr_en),
        .do_pin(do_pin), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_do(input logic exp, input string req);
        check(do_pin === exp, req, {31'b0, do_pin}, {31'b0, exp});
    endtask

    task automatic check_array(input logic [DATA_W-1:0] exp, input string req);
        int bad = 0;
        logic [DATA_W-1:0] first_bad = exp;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a);
            #0.1;
            if (rd_data !== exp) begin
                if (bad == 0) first_bad = rd_data;
                bad++;
            end
        end
        check(bad == 0, req, 32'(first_bad), 32'(exp));
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            di = v[i];
            tick(3);
            sk = 1'b1;
            tick(4);
            sk = 1'b0;
            tick(1);
        end
    endtask

    // Frame builders: start 1, opcode 00, 6-bit address field.
    task automatic send_erase();
        send_bits({23'b0, 3'b100, 2'b10, 4'b1011}, 9);
    endtask

    task automatic send_write(input logic [7:0] d);
        send_bits({15'b0, 3'b100, 2'b01, 4'b0110, d}, 17);
    endtask

    task automatic t_reset();
        check_do(1'bz, "R6 reset float");
        check_array(8'h00, "R1 reset clear");
    endtask

    task automatic t_write_all(input logic [7:0] d, input logic [7:0] old);
        cs = 1'b1; tick(4);
        send_write(d);
        tick(6);
        check_array(old, "R3 no change while selected");
        cs = 1'b0; tick(CSMIN + 6);
        cs = 1'b1; tick(6);
        check_do(1'b0, "R5 busy low");
        check_array(old, "R4 unchanged mid-cycle");
        tick(CYC);
        check_do(1'b1, "R5 ready high");
        check_array(d, "R2 write-all");
        cs = 1'b0; tick(6);
        check_do(1'bz, "R6 float after deselect");
        cs = 1'b1; tick(6);
        check_do(1'bz, "R6 session closed");
        cs = 1'b0; tick(4);
    endtask

    task automatic t_erase_with_zeros();
        cs = 1'b1; tick(4);
        send_bits(32'b0, 3);   // leading zeros before start bit (R10)
        send_erase();
        tick(2);
        cs = 1'b0;
        tick(CYC - 12);
        check_array(8'hC6, "R4 old data before last clock");
        tick(30);
        check_array(8'hFF, "R1 erase-all with leading zeros R10");
    endtask

    task automatic t_disabled();
        wr_en = 1'b0;
        cs = 1'b1; tick(4);
        send_write(8'h3C);
        cs = 1'b0; tick(CSMIN + 4);
        wr_en = 1'b1;
        cs = 1'b1; tick(6);
        check_do(1'bz, "R8 no status when disabled");
        cs = 1'b0; tick(CYC + 20);
        check_array(8'hFF, "R8 disabled write ignored");
    endtask

    task automatic t_truncated();
        cs = 1'b1; tick(4);
        send_bits({15'b0, 3'b100, 2'b01, 4'b0110, 8'h12} >> 3, 14);
        cs = 1'b0; tick(CYC + 20);
        check_array(8'hFF, "R9 truncated frame aborted");
        cs = 1'b1; tick(6);
        check_do(1'bz, "R9 no cycle started");
        cs = 1'b0; tick(4);
    endtask

    task automatic t_bad_codes();
        cs = 1'b1; tick(4);
        send_bits({15'b0, 3'b100, 2'b11, 4'b0000, 8'h00}, 17);
        cs = 1'b0; tick(CYC + 20);
        check_array(8'hFF, "R10 qualifier 11 ignored");
        cs = 1'b1; tick(4);
        send_bits({15'b0, 3'b101, 2'b01, 4'b0000, 8'h00}, 17);
        cs = 1'b0; tick(CYC + 20);
        check_array(8'hFF, "R10 opcode 01 ignored");
    endtask

    task automatic t_early_reselect();
        cs = 1'b1; tick(4);
        send_write(8'h5A);
        cs = 1'b0; tick(2);
        cs = 1'b1; tick(5);
        check_do(1'bz, "R7 reselect too early");
        cs = 1'b0; tick(CYC + 20);
        cs = 1'b1; tick(5);
        check_do(1'b1, "R5 ready after cycle");
        check_array(8'h5A, "R2 overwrite without erase");
        cs = 1'b0; tick(4);
    endtask

    task automatic t_busy_overlap();
        cs = 1'b1; tick(4);
        send_write(8'h11);
        cs = 1'b0; tick(CSMIN + 4);
        cs = 1'b1; tick(4);
        send_erase();
        cs = 1'b0; tick(CYC + 20);
        check_array(8'h11, "R11 command during cycle ignored");
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_write_all(8'hC6, 8'h00);
        t_erase_with_zeros();
        t_disabled();
        t_truncated();
        t_bad_codes();
        t_early_reselect();
        t_busy_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule